// File: doc/BRIEF.md
# Frame-Synchronized Serial Port with Programmable Data Delay

This block is one serial channel pair: a receiver and a transmitter that each move 8-bit words, most significant bit first. Each side runs directly on its own serial bit clock and is framed by an active-high frame-sync input. A shared 2-bit control selects how many bit periods separate the accepted frame sync from the first data bit: zero, one or two.

The receiver samples its data input and its frame sync on falling clock edges. It collects one word per frame and presents it with a one-cycle valid strobe. The transmitter samples its frame sync on rising edges and shifts out the word presented on its parallel input. With zero delay, the first transmit bit has to appear in the same bit period as the sync itself, so it is routed combinationally from a staged copy of the word. With a two-bit delay, the slot just after the sync carries a framing bit. The receiver drops that bit, and the transmitter leaves the slot undriven.

A frame sync that comes while a word is still in flight is ignored. Outside its data slots the transmitter holds its data output low and its output enable low.

Top module: `sfp_port`

## Requirements
- R1: The control `delay_sel` is decoded as 00 = zero-bit delay, 01 = one-bit delay and 10 = two-bit delay. The reserved code 11 behaves exactly like 10. Each side samples this control only at the edge where it accepts a frame sync.
- R2: While idle, the receiver accepts a frame sync at any falling edge m of `rx_clk` at which `rx_fs` is high. It then samples the most significant bit at falling edge m+D, where D is the decoded delay, and the remaining seven bits at the seven following falling edges in order. A sync held high across several idle edges starts a new frame at each of those edges.
- R3: With zero delay, while the transmitter is idle and `tx_fs` is high, `tx_dout` shows the most significant bit of the staged word and `tx_oe` is high, with no clock edge in between.
- R4: The transmitter accepts a frame sync at a rising edge k of `tx_clk` while idle. For D of 1 or 2, bit i (i = 0 is the most significant bit) is driven at rising edge k+D+i-1. For D = 0, bits 1 to 7 are driven at edges k to k+6. The word sent is the `tx_word` value sampled at edge k-1.
- R5: With two-bit delay, the receiver discards the bit sampled at falling edge m+1. The transmitter keeps `tx_dout` and `tx_oe` low for the bit period that starts at edge k.
- R6: After the last bit of a frame is sampled at falling edge m+D+7, `rx_word` holds the assembled byte (first received bit in bit 7) and `rx_valid` is high for exactly one `rx_clk` cycle. `rx_word` holds its value until the next word completes.
- R7: A frame sync is ignored while a word is in progress. For the receiver this covers falling edges m+1 through m+D+7. For the transmitter it covers rising edges k+1 through k+D+7.
- R8: Outside its data slots the transmitter drives `tx_dout` low and `tx_oe` low. Whenever `tx_oe` is low, `tx_dout` is low.
- R9: While `rst` is high at a clock edge, that side returns to idle. The receiver's `rx_word` and `rx_valid` become 0. The transmitter's `tx_dout` and `tx_oe` become 0, and its staged word becomes 0.
- R10: A frame sync at the edge right after a frame ends (m+D+8 for the receiver, k+D+8 for the transmitter) is accepted. This gives gapless frames every D+8 bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| delay_sel | input | 2 | Data delay code: 00 zero, 01 one, 10 or 11 two bit periods |
| rx_clk | input | 1 | Receive bit clock; sampling on falling edges |
| rx_fs | input | 1 | Receive frame sync, active high |
| rx_din | input | 1 | Receive serial data |
| rx_word | output | 8 | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe marking a newly completed word |
| tx_clk | input | 1 | Transmit bit clock; data changes on rising edges |
| tx_fs | input | 1 | Transmit frame sync, active high |
| tx_word | input | 8 | Parallel word to transmit |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | High while a transmit data bit is being driven |

## Verification
The bench builds the port with the default 8-bit word and drives both bit clocks from one source, so the receive and transmit frames line up edge for edge. At this word width the busy window, the frame period D+8 and the two-bit framing slot are short enough that every delay code, including the reserved one, is run with sparse frames, gapless frames and syncs that land inside a frame. Changing `tx_word` on every bit period makes the exact sampling edge of the sent word visible. Holding frame sync high for many periods exercises both retriggering at idle edges and the combinational first-bit path.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef logic [1:0] dly_code_t;

  function automatic logic [1:0] dly_bits(input dly_code_t code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/sfp_dly_decode.sv
module sfp_dly_decode
  import sfp_pkg::*;
(
  input  dly_code_t  code,
  output logic [1:0] bits
);
  always_comb bits = dly_bits(code);
endmodule

// File: rtl/sfp_rx.sv
module sfp_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic              din,
  input  logic [1:0]        dly,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              active;
  logic              skip;
  logic [CW-1:0]     left;
  logic [WORD_W-1:0] sh;

  always_ff @(negedge clk) begin
    if (rst) begin
      active <= 1'b0;
      skip   <= 1'b0;
      left   <= '0;
      sh     <= '0;
      word   <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!active) begin
        if (fs) begin
          active <= 1'b1;
          case (dly)
            2'd0: begin
              sh   <= {sh[WORD_W-2:0], din};
              left <= CW'(WORD_W - 1);
              skip <= 1'b0;
            end
            2'd1: begin
              left <= CW'(WORD_W);
              skip <= 1'b0;
            end
            default: begin
              left <= CW'(WORD_W);
              skip <= 1'b1;
            end
          endcase
        end
      end else if (skip) begin
        skip <= 1'b0;
      end else begin
        sh   <= {sh[WORD_W-2:0], din};
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          word   <= {sh[WORD_W-2:0], din};
          valid  <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end

  // R6
  rx_strobe_once_chk: assert property (@(negedge clk) disable iff (rst)
    valid |=> !valid);

  // R6
  rx_done_idle_chk: assert property (@(negedge clk) disable iff (rst)
    valid |-> !active);

  // R7
  rx_busy_hold_chk: assert property (@(negedge clk) disable iff (rst)
    (active && !skip && left > CW'(1)) |=> active);
endmodule

// File: rtl/sfp_tx.sv
module sfp_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs,
  input  logic [1:0]        dly,
  input  logic [WORD_W-1:0] word_in,
  output logic              dout,
  output logic              oe
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              active;
  logic [CW-1:0]     left;
  logic [WORD_W-1:0] stage;
  logic [WORD_W-1:0] sh;
  logic              dout_r;
  logic              oe_r;
  logic              accept;
  logic              zero_path;

  assign accept    = !active && fs;
  assign zero_path = !rst && accept && (dly == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left   <= '0;
      stage  <= '0;
      sh     <= '0;
      dout_r <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      if (!accept) stage <= word_in;
      if (!active) begin
        if (fs) begin
          active <= 1'b1;
          case (dly)
            2'd0: begin
              dout_r <= stage[WORD_W-2];
              oe_r   <= 1'b1;
              sh     <= stage << 2;
              left   <= CW'(WORD_W - 2);
            end
            2'd1: begin
              dout_r <= stage[WORD_W-1];
              oe_r   <= 1'b1;
              sh     <= stage << 1;
              left   <= CW'(WORD_W - 1);
            end
            default: begin
              dout_r <= 1'b0;
              oe_r   <= 1'b0;
              sh     <= stage;
              left   <= CW'(WORD_W);
            end
          endcase
        end
      end else if (left != '0) begin
        dout_r <= sh[WORD_W-1];
        oe_r   <= 1'b1;
        sh     <= sh << 1;
        left   <= left - CW'(1);
      end else begin
        dout_r <= 1'b0;
        oe_r   <= 1'b0;
        active <= 1'b0;
      end
    end
  end

  assign dout = zero_path ? stage[WORD_W-1] : dout_r;
  assign oe   = zero_path | oe_r;

  // R8
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout);

  // R3
  tx_zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && fs && dly == 2'd0) |-> oe);

  // R7
  tx_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && left != '0) |=> active);
endmodule

// File: rtl/sfp_port.sv
module sfp_port #(
  parameter int WORD_W = 8
) (
  input  logic              rst,
  input  logic [1:0]        delay_sel,
  input  logic              rx_clk,
  input  logic              rx_fs,
  input  logic              rx_din,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  input  logic              tx_clk,
  input  logic              tx_fs,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dout,
  output logic              tx_oe
);
  logic [1:0] dly;

  sfp_dly_decode u_dec (
    .code (delay_sel),
    .bits (dly)
  );

  sfp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk   (rx_clk),
    .rst   (rst),
    .fs    (rx_fs),
    .din   (rx_din),
    .dly   (dly),
    .word  (rx_word),
    .valid (rx_valid)
  );

  sfp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk     (tx_clk),
    .rst     (rst),
    .fs      (tx_fs),
    .dly     (dly),
    .word_in (tx_word),
    .dout    (tx_dout),
    .oe      (tx_oe)
  );
endmodule

// File: tb/sim_sfp_port.sv
module sim_sfp_port;
  localparam int CLK_PERIOD = 10;

  logic       sclk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] delay_sel = 2'b00;
  logic       rx_fs = 1'b0;
  logic       rx_din = 1'b0;
  logic       tx_fs = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic [7:0] rx_word;
  logic       rx_valid;
  logic       tx_dout;
  logic       tx_oe;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string cur_req = "R9";
  logic [15:0] lf = 16'hACE1;
  logic [1:0]  dnext = 2'b00;

  sfp_port u0 (
    .rst(rst), .delay_sel(delay_sel),
    .rx_clk(sclk), .rx_fs(rx_fs), .rx_din(rx_din),
    .rx_word(rx_word), .rx_valid(rx_valid),
    .tx_clk(sclk), .tx_fs(tx_fs), .tx_word(tx_word),
    .tx_dout(tx_dout), .tx_oe(tx_oe)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b11) ? 2 : int'(c);
  endfunction

  // transmit reference state
  int tn = 0, tk = 0, td = 0;
  bit tbusy = 0;
  logic [7:0] tword = 0, prev_word = 0;
  logic e_dout = 0, e_oe = 0;
  // receive reference state
  int rn = 0, rm = 0, rd = 0;
  bit rbusy = 0;
  logic [7:0] rcol = 0, ew = 0;
  logic ev = 0;

  task automatic check1(input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %b exp %b at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic check8(input string what, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %h exp %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic tx_step();
    if (rst) begin
      tbusy = 0;
      prev_word = 0;
    end else begin
      if (!tbusy && tx_fs) begin
        tbusy = 1; tk = tn; td = dec(delay_sel); tword = prev_word;
      end else if (tbusy && tn == tk + td + 7) begin
        tbusy = 0;
      end
      prev_word = tx_word;
    end
    e_dout = 0; e_oe = 0;
    if (tbusy) begin
      int i;
      i = tn - tk - td + 1;
      if (i >= 0 && i <= 7) begin
        e_dout = tword[7 - i];
        e_oe = 1;
      end
    end
    tn++;
  endtask

  task automatic tx_compare(input string when);
    logic xd, xo;
    xd = e_dout; xo = e_oe;
    if (!rst && !tbusy && tx_fs && dec(delay_sel) == 0) begin
      xd = prev_word[7]; xo = 1;
    end
    check1({"tx_dout ", when}, tx_dout, xd);
    check1({"tx_oe ", when}, tx_oe, xo);
  endtask

  task automatic rx_step();
    if (rst) begin
      rbusy = 0; ev = 0; ew = 0;
    end else begin
      ev = 0;
      if (!rbusy && rx_fs) begin
        rbusy = 1; rm = rn; rd = dec(delay_sel); rcol = 0;
      end
      if (rbusy) begin
        int rel;
        rel = rn - rm;
        if (rel >= rd && rel <= rd + 7) rcol = {rcol[6:0], rx_din};
        if (rel == rd + 7) begin
          ew = rcol; ev = 1; rbusy = 0;
        end
      end
    end
    rn++;
  endtask

  initial begin
    forever begin
      @(posedge sclk);
      #1;
      tx_step();
      tx_compare("after edge");
      #3;
      tx_compare("after input change");
      @(negedge sclk);
      #1;
      rx_step();
      check1("rx_valid", rx_valid, ev);
      check8("rx_word", rx_word, ew);
    end
  end

  task automatic cyc(input logic fsv);
    @(posedge sclk);
    #2;
    rx_fs = fsv;
    tx_fs = fsv;
    delay_sel = dnext;
    rx_din = lf[0];
    tx_word = lf[15:8];
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  task automatic pulses(input int period, input int count);
    for (int i = 0; i < count; i++)
      for (int j = 0; j < period; j++) cyc(j == 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R9";
    cyc(1'b0); cyc(1'b1); cyc(1'b0); cyc(1'b1);
    @(posedge sclk); #2; rst = 1'b0;
    idle(6);
    cur_req = "R9"; cyc(1'b1); cyc(1'b0); cyc(1'b0);
    @(posedge sclk); #2; rst = 1'b1;
    idle(3);
    @(posedge sclk); #2; rst = 1'b0;
    idle(4);
    for (int d = 0; d < 4; d++) begin
      int dd;
      dd = (d == 3) ? 2 : d;
      dnext = 2'(d);
      case (d)
        0: cur_req = "R3";
        1: cur_req = "R4";
        2: cur_req = "R5";
        default: cur_req = "R1";
      endcase
      idle(3);
      pulses(dd + 13, 3);
      cur_req = "R10";
      pulses(dd + 8, 5);
      idle(12);
      cur_req = "R7";
      cyc(1'b1); idle(2); cyc(1'b1); idle(dd + 3);
      cyc(1'b1); cyc(1'b1); idle(dd + 9);
      cyc(1'b1); idle(dd + 6); cyc(1'b1); idle(12);
    end
    cur_req = "R2";
    for (int d = 0; d < 3; d++) begin
      dnext = 2'(d);
      idle(3);
      for (int i = 0; i < 30; i++) cyc(1'b1);
      idle(12);
    end
    cur_req = "R8";
    dnext = 2'b00;
    idle(20);
    cur_req = "R6";
    dnext = 2'b01;
    pulses(15, 4);
    idle(12);
    done = 1;
    summary();
    $finish;
  end
endmodule